// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block produces the character-clock timing for a character-cell display controller. On every character clock it drives display enable, horizontal sync, vertical sync, a 14-bit refresh memory address and a 5-bit raster row address. It also keeps a frame count that blink logic can use. A separate register block, which is not part of this design, supplies every geometry value as a static input. That block changes the values only while reset is held.

A frame is built from character rows, and each character row is made of `max_row + 1` scan lines. After the last programmed character row comes an optional adjust period of extra scan lines. The refresh address steps once per character. Each character row starts at the address that followed the last displayed character of the row before it. Display enable can be delayed by zero, one or two character clocks, so that it lines up with downstream memory and character-generator latency.

Top module: `crt_raster_timer`

## Requirements
- R1: A horizontal position counter steps from 0 to `h_total` and then returns to 0, so each scan line lasts `h_total + 1` clocks, and every scan line begins with the address reload described in R2.
- R2: At the first clock of each new character row, `ma` equals the start address of the previous row plus `h_disp`. Within a row, each scan line starts again from that row's start address.
- R3: Inside a scan line, `ma` rises by one per clock, wrapping modulo 2^14.
- R4: `hsync` is high exactly on the clocks whose horizontal position lies in `[h_sync_pos, h_sync_pos + h_sync_wid)`. A width of 0 gives no pulse at all.
- R5: `ra` counts 0 to `max_row` over the scan lines of a character row and then returns to 0.
- R6: After character row `v_total` there are `v_adjust` extra scan lines. During these lines `ra` is 0 and each line starts from the address that follows the last row. A value of 0 adds no lines.
- R7: `vsync` rises on the first scan line of character row `v_sync_pos` and stays high for `v_sync_lines` scan lines. A value of 0 means 16 lines.
- R8: At each frame start, `ma` reloads `start_addr` and `frame_cnt` increments, wrapping modulo 2^FW.
- R9: `de` is the horizontal visible flag (position < `h_disp`) delayed by `skew` clocks, ANDed with the vertical visible flag. The `skew` encoding is 0 for no delay, 1 for one clock and 2 for two clocks; 3 behaves as 0. Vertical visibility holds for character rows below `v_disp`, and it holds during adjust lines only when `v_disp > v_total`. Before reset release, the delayed history reads as not visible.
- R10: While `rst_n` is low, all counters are zero, `hsync` and `vsync` are low, `ma` equals `start_addr`, and `frame_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_total | input | 8 | Last horizontal position of a scan line |
| h_disp | input | 8 | Number of displayed characters per line |
| h_sync_pos | input | 8 | Horizontal position where hsync begins |
| h_sync_wid | input | 4 | Hsync width in clocks, 0 for none |
| v_total | input | 7 | Last character row index before adjust |
| v_disp | input | 7 | Number of displayed character rows |
| v_sync_pos | input | 7 | Character row where vsync begins |
| v_sync_lines | input | 4 | Vsync length in scan lines, 0 for 16 |
| v_adjust | input | 5 | Extra scan lines after the last row |
| max_row | input | 5 | Last raster row within a character row |
| start_addr | input | 14 | Refresh address of the first character |
| skew | input | 2 | Display enable delay select |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| ma | output | 14 | Refresh memory address |
| ra | output | 5 | Raster row address |
| frame_cnt | output | 8 | Completed-frame count |

## Verification
The assertions assume that the geometry inputs stay constant outside reset. They also assume `h_disp` lies between 1 and `h_total - 1`, the hsync pulse starts at position 1 or later and ends by `h_total`, `v_disp` is at least 1, `v_sync_pos` lies between 1 and `v_total`, and the vsync pulse ends within the frame. The stimulus holds reset while it loads each geometry set and only uses sets chosen to meet these limits. Those sets still reach the edges: zero and maximum sync width, a 16-line vsync, zero and nonzero adjust, every skew value, a single-line character row, and a start address close enough to the top that the address wraps.

// File: rtl/rt_pkg.sv
// Shared types and constants for the raster timing generator.
// Assumes: nothing; holds declarations only.
package rt_pkg;
    // Encoding of the display-enable delay selection.
    typedef enum logic [1:0] {
        SKEW_NONE = 2'd0,
        SKEW_ONE  = 2'd1,
        SKEW_TWO  = 2'd2,
        SKEW_RSVD = 2'd3
    } skew_e;

    // Width of the horizontal and vertical sync length counters.
    localparam int SYNC_CW = 4;
endpackage

// File: rtl/rt_hcount.sv
// Horizontal character counter with horizontal visible flag and sync pulse.
// Assumes: geometry inputs are stable outside reset; h_sync_pos >= 1.
module rt_hcount #(
    parameter int HW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HW-1:0]          h_total,
    input  logic [HW-1:0]          h_disp,
    input  logic [HW-1:0]          h_sync_pos,
    input  logic [rt_pkg::SYNC_CW-1:0] h_sync_wid,
    output logic                   eol_o,
    output logic                   at_hdisp_o,
    output logic                   hvis_o,
    output logic                   hsync_o
);
    localparam int CW = rt_pkg::SYNC_CW;

    logic [HW-1:0] hcnt;
    logic [HW-1:0] hcnt_nxt;
    logic [CW-1:0] hs_cnt;
    logic          hs;

    // Decode end of line, display boundary and next position.
    always_comb begin
        eol_o      = (hcnt == h_total);
        at_hdisp_o = (hcnt == h_disp);
        hvis_o     = (hcnt < h_disp);
        hcnt_nxt   = eol_o ? '0 : hcnt + 1'b1;
    end

    // Advance the character position.
    always_ff @(posedge clk) begin
        if (!rst_n) hcnt <= '0;
        else        hcnt <= hcnt_nxt;
    end

    // Start the sync pulse at the programmed position and end it after the width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs     <= 1'b0;
            hs_cnt <= '0;
        end else if (hcnt_nxt == h_sync_pos && h_sync_wid != '0) begin
            hs     <= 1'b1;
            hs_cnt <= CW'(1);
        end else if (hs) begin
            if (hs_cnt == h_sync_wid) hs <= 1'b0;
            else                      hs_cnt <= hs_cnt + 1'b1;
        end
    end

    assign hsync_o = hs;

    AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |=> (hcnt == '0)); // R1
    AST_HSYNC_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sync_wid == '0) |-> !hsync_o); // R4
endmodule

// File: rtl/rt_vcount.sv
// Vertical sequencer: raster row, character row, adjust period, vertical sync,
// vertical visible flag and frame counter. All state moves only at end of line.
// Assumes: geometry inputs stable outside reset; v_sync_pos in 1..v_total; v_disp >= 1.
module rt_vcount #(
    parameter int VW = 7,
    parameter int RW = 5,
    parameter int FW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       eol,
    input  logic [VW-1:0]              v_total,
    input  logic [VW-1:0]              v_disp,
    input  logic [VW-1:0]              v_sync_pos,
    input  logic [rt_pkg::SYNC_CW-1:0] v_sync_lines,
    input  logic [RW-1:0]              v_adjust,
    input  logic [RW-1:0]              max_row,
    output logic [RW-1:0]              ra_o,
    output logic                       vvis_o,
    output logic                       vsync_o,
    output logic                       row_wrap_o,
    output logic                       frame_end_o,
    output logic [FW-1:0]              frame_o
);
    localparam int CW = rt_pkg::SYNC_CW;

    logic [RW-1:0] ra;
    logic [VW-1:0] row;
    logic [VW-1:0] row_nxt;
    logic [RW-1:0] adj_cnt;
    logic [RW-1:0] adj_inc;
    logic          in_adj;
    logic          vvis;
    logic          vs;
    logic [CW-1:0] vs_cnt;
    logic [CW-1:0] vs_inc;
    logic [FW-1:0] frame;
    logic          last_ra;
    logic          last_row;
    logic          enter_adj;
    logic          row_step;

    // Decode row wrap, adjust entry and frame end for this line.
    always_comb begin
        last_ra     = (ra == max_row);
        last_row    = (row == v_total);
        row_nxt     = row + 1'b1;
        adj_inc     = adj_cnt + 1'b1;
        vs_inc      = vs_cnt + 1'b1;
        row_wrap_o  = eol && !in_adj && last_ra;
        enter_adj   = row_wrap_o && last_row && (v_adjust != '0);
        row_step    = row_wrap_o && !last_row;
        frame_end_o = eol && ((in_adj && adj_inc == v_adjust) ||
                              (row_wrap_o && last_row && v_adjust == '0));
    end

    // Step raster row, character row and adjust period at end of line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra      <= '0;
            row     <= '0;
            in_adj  <= 1'b0;
            adj_cnt <= '0;
            vvis    <= 1'b1;
        end else if (eol) begin
            if (frame_end_o) begin
                ra     <= '0;
                row    <= '0;
                in_adj <= 1'b0;
                vvis   <= 1'b1;
            end else if (in_adj) begin
                adj_cnt <= adj_inc;
            end else if (last_ra) begin
                ra <= '0;
                if (enter_adj) begin
                    in_adj  <= 1'b1;
                    adj_cnt <= '0;
                end else begin
                    row <= row_nxt;
                    if (row_nxt == v_disp) vvis <= 1'b0;
                end
            end else begin
                ra <= ra + 1'b1;
            end
        end
    end

    // Start vertical sync on entry to its row and count its scan lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs     <= 1'b0;
            vs_cnt <= '0;
        end else if (eol) begin
            if (row_step && row_nxt == v_sync_pos) begin
                vs     <= 1'b1;
                vs_cnt <= '0;
            end else if (vs) begin
                vs_cnt <= vs_inc;
                if (vs_inc == v_sync_lines) vs <= 1'b0;
            end
        end
    end

    // Count completed frames.
    always_ff @(posedge clk) begin
        if (!rst_n)           frame <= '0;
        else if (frame_end_o) frame <= frame + 1'b1;
    end

    assign ra_o    = ra;
    assign vvis_o  = vvis;
    assign vsync_o = vs;
    assign frame_o = frame;

    AST_RA_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ra <= max_row); // R5
    AST_ADJUST_RA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_adj |-> (ra == '0)); // R6
    AST_VSYNC_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !eol |=> $stable(vsync_o)); // R7
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (frame_o == FW'($past(frame_o) + 1'b1))); // R8
endmodule

// File: rtl/rt_addr.sv
// Refresh address generator: steps per clock, captures the next row start at
// the display boundary and reloads at line, row and frame starts.
// Assumes: h_disp < h_total so the capture happens inside every line.
module rt_addr #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_addr,
    input  logic          eol,
    input  logic          at_hdisp,
    input  logic          row_wrap,
    input  logic          frame_end,
    output logic [AW-1:0] ma_o
);
    logic [AW-1:0] ma;
    logic [AW-1:0] line_addr;
    logic [AW-1:0] next_row_addr;

    // Capture the address following the last displayed character.
    always_ff @(posedge clk) begin
        if (!rst_n)        next_row_addr <= start_addr;
        else if (at_hdisp) next_row_addr <= ma;
    end

    // Step the address, reloading at line, row and frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma        <= start_addr;
            line_addr <= start_addr;
        end else if (eol) begin
            if (frame_end) begin
                ma        <= start_addr;
                line_addr <= start_addr;
            end else if (row_wrap) begin
                ma        <= next_row_addr;
                line_addr <= next_row_addr;
            end else begin
                ma <= line_addr;
            end
        end else begin
            ma <= ma + 1'b1;
        end
    end

    assign ma_o = ma;

    AST_MA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !eol |=> (ma_o == AW'($past(ma_o) + 1'b1))); // R3
    AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (ma_o == start_addr)); // R8
endmodule

// File: rtl/rt_skew.sv
// Display enable with a selectable delay of the horizontal visible flag.
// Assumes: skew stable outside reset; history reads as not visible after reset.
module rt_skew #(
    parameter int MAXSKEW = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hvis,
    input  logic       vvis,
    input  logic [1:0] skew,
    output logic       de_o
);
    import rt_pkg::*;

    logic [MAXSKEW-1:0] hist;
    logic               sel;

    // Shift the horizontal visible flag into the history.
    generate
        if (MAXSKEW == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= hvis;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[MAXSKEW-2:0], hvis};
            end
        end
    endgenerate

    // Pick the delayed tap and gate with vertical visibility.
    always_comb begin
        case (skew_e'(skew))
            SKEW_ONE: sel = hist[0];
            SKEW_TWO: sel = hist[MAXSKEW-1];
            default:  sel = hvis;
        endcase
        de_o = sel & vvis;
    end

    AST_DE_NEEDS_VVIS: assert property (@(posedge clk) disable iff (!rst_n)
        !vvis |-> !de_o); // R9
endmodule

// File: rtl/crt_raster_timer.sv
// Top of the raster timing generator: ties the horizontal counter, vertical
// sequencer, address generator and display-enable delay together.
// Assumes: geometry inputs come from a register block and change only under reset.
module crt_raster_timer #(
    parameter int HW = 8,
    parameter int VW = 7,
    parameter int RW = 5,
    parameter int AW = 14,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_disp,
    input  logic [HW-1:0] h_sync_pos,
    input  logic [3:0]    h_sync_wid,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_disp,
    input  logic [VW-1:0] v_sync_pos,
    input  logic [3:0]    v_sync_lines,
    input  logic [RW-1:0] v_adjust,
    input  logic [RW-1:0] max_row,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    skew,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic [AW-1:0] ma,
    output logic [RW-1:0] ra,
    output logic [FW-1:0] frame_cnt
);
    logic eol;
    logic at_hdisp;
    logic hvis;
    logic vvis;
    logic row_wrap;
    logic frame_end;

    rt_hcount #(.HW(HW)) u_h (
        .clk(clk), .rst_n(rst_n),
        .h_total(h_total), .h_disp(h_disp),
        .h_sync_pos(h_sync_pos), .h_sync_wid(h_sync_wid),
        .eol_o(eol), .at_hdisp_o(at_hdisp), .hvis_o(hvis), .hsync_o(hsync)
    );

    rt_vcount #(.VW(VW), .RW(RW), .FW(FW)) u_v (
        .clk(clk), .rst_n(rst_n), .eol(eol),
        .v_total(v_total), .v_disp(v_disp), .v_sync_pos(v_sync_pos),
        .v_sync_lines(v_sync_lines), .v_adjust(v_adjust), .max_row(max_row),
        .ra_o(ra), .vvis_o(vvis), .vsync_o(vsync),
        .row_wrap_o(row_wrap), .frame_end_o(frame_end), .frame_o(frame_cnt)
    );

    rt_addr #(.AW(AW)) u_a (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
        .eol(eol), .at_hdisp(at_hdisp), .row_wrap(row_wrap),
        .frame_end(frame_end), .ma_o(ma)
    );

    rt_skew #(.MAXSKEW(2)) u_s (
        .clk(clk), .rst_n(rst_n), .hvis(hvis), .vvis(vvis),
        .skew(skew), .de_o(de)
    );

    AST_SYNC_LOW_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> (!hsync && !vsync && frame_cnt == '0)); // R10
endmodule

// File: tb/sim_crt_raster_timer.sv
module sim_crt_raster_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  h_total = 8'd9, h_disp = 8'd6, h_sync_pos = 8'd7;
    logic [3:0]  h_sync_wid = 4'd2;
    logic [6:0]  v_total = 7'd3, v_disp = 7'd2, v_sync_pos = 7'd2;
    logic [3:0]  v_sync_lines = 4'd3;
    logic [4:0]  v_adjust = 5'd2, max_row = 5'd2;
    logic [13:0] start_addr = 14'h100;
    logic [1:0]  skew = 2'd0;
    logic        de, hsync, vsync;
    logic [13:0] ma;
    logic [4:0]  ra;
    logic [7:0]  frame_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic        de;
        logic        hs;
        logic        vs;
        logic [13:0] ma;
        logic [4:0]  ra;
        logic [7:0]  fr;
        string       mtag;
        string       rtag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    crt_raster_timer u0 (
        .clk(clk), .rst_n(rst_n),
        .h_total(h_total), .h_disp(h_disp), .h_sync_pos(h_sync_pos),
        .h_sync_wid(h_sync_wid), .v_total(v_total), .v_disp(v_disp),
        .v_sync_pos(v_sync_pos), .v_sync_lines(v_sync_lines),
        .v_adjust(v_adjust), .max_row(max_row), .start_addr(start_addr),
        .skew(skew), .de(de), .hsync(hsync), .vsync(vsync), .ma(ma),
        .ra(ra), .frame_cnt(frame_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs at clock index t after reset release, from the requirements.
    function automatic exp_t model(input int t);
        exp_t e;
        int p, r, l, line, h, fl, row, n, base, sk, td;
        bit adj, hv, vv;
        p    = int'(h_total) + 1;
        r    = int'(max_row) + 1;
        l    = (int'(v_total) + 1) * r + int'(v_adjust);
        line = t / p;
        h    = t % p;
        fl   = line % l;
        adj  = fl >= (int'(v_total) + 1) * r;
        row  = adj ? int'(v_total) : fl / r;
        base = adj ? (int'(v_total) + 1) * int'(h_disp) : row * int'(h_disp);
        sk   = (skew == 2'd1) ? 1 : (skew == 2'd2) ? 2 : 0;
        td   = t - sk;
        hv   = (td >= 0) && ((td % p) < int'(h_disp));
        vv   = adj ? (v_disp > v_total) : (row < int'(v_disp));
        n    = (v_sync_lines == 4'd0) ? 16 : int'(v_sync_lines);
        e.de = hv && vv;
        e.hs = (h_sync_wid != 4'd0) && (h >= int'(h_sync_pos)) &&
               (h < int'(h_sync_pos) + int'(h_sync_wid));
        e.vs = (fl >= int'(v_sync_pos) * r) && (fl < int'(v_sync_pos) * r + n);
        e.ma = 14'((int'(start_addr) + base + h) % 16384);
        e.ra = adj ? 5'd0 : 5'(fl % r);
        e.fr = 8'((line / l) % 256);
        if (fl == 0 && h == 0)  e.mtag = "R8";
        else if (adj)           e.mtag = "R6";
        else if (h == 0)        e.mtag = "R1/R2";
        else                    e.mtag = "R3";
        e.rtag = adj ? "R6" : "R5";
        return e;
    endfunction

    // Monitor: pop one expected item per clock and compare with the outputs.
    always @(negedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(ma == e.ma, {e.mtag, " ma"}, int'(ma), int'(e.ma));
            check(ra == e.ra, {e.rtag, " ra"}, int'(ra), int'(e.ra));
            check(hsync == e.hs, "R4 hsync", int'(hsync), int'(e.hs));
            check(vsync == e.vs, "R7 vsync", int'(vsync), int'(e.vs));
            check(de == e.de, "R9 de", int'(de), int'(e.de));
            check(frame_cnt == e.fr, "R8 frame_cnt", int'(frame_cnt), int'(e.fr));
        end
    end

    // Driver: load a geometry under reset, check the reset state, queue expectations.
    task automatic run_cfg(input int ht, input int hd, input int hsp, input int hw,
                           input int vt, input int vd, input int vsp, input int vsl,
                           input int va, input int mr, input int sa, input int sk,
                           input int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        h_total = 8'(ht); h_disp = 8'(hd); h_sync_pos = 8'(hsp); h_sync_wid = 4'(hw);
        v_total = 7'(vt); v_disp = 7'(vd); v_sync_pos = 7'(vsp); v_sync_lines = 4'(vsl);
        v_adjust = 5'(va); max_row = 5'(mr); start_addr = 14'(sa); skew = 2'(sk);
        repeat (3) @(negedge clk);
        #2;
        check(ma == 14'(sa), "R10 reset ma", int'(ma), sa);
        check(!hsync && !vsync, "R10 reset sync", int'({hsync, vsync}), 0);
        check(ra == 5'd0 && frame_cnt == 8'd0, "R10 reset counters",
              int'({ra, frame_cnt}), 0);
        @(negedge clk);
        for (int t = 0; t < ncyc; t++) q.push_back(model(t));
        rst_n = 1'b1;
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        // Adjust of two lines, skew 0, two-clock hsync.
        run_cfg(9, 6, 7, 2, 3, 2, 2, 3, 2, 2, 'h100, 0, 440);
        // Zero-width hsync, no adjust, 16-line vsync, address wrap, skew 1.
        run_cfg(7, 5, 6, 0, 5, 4, 1, 0, 0, 3, 'h3FF8, 1, 600);
        // Maximum hsync width, single-line rows, visible adjust, skew 2.
        run_cfg(20, 12, 3, 15, 2, 3, 1, 1, 3, 0, 'h0040, 2, 420);
        // One adjust line, five-line rows, one-clock hsync, reserved skew acts as 0.
        run_cfg(11, 8, 9, 1, 1, 1, 1, 2, 1, 4, 'h2000, 3, 420);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule